// File: doc/BRIEF.md
# Two-Thread Partitioned Micro-Op Queue

This block buffers micro-operations for two hardware threads that share one storage array. In the dual-thread mode the array is split into two fixed halves, one per thread, so a stalled or bursty thread can only fill its own half and cannot starve its sibling. In either of the two single-thread modes the partition is merged: the one active thread may occupy every entry, and the idle thread's write port is closed.

Each thread pushes through its own valid/ready write port. A single read port drains the queue toward the next pipeline stage. When both threads hold entries the reader alternates between them on every transfer. When only one thread holds entries it is served on every cycle without an idle slot. Order is kept within each thread.

The operating mode is selected by a level input. A new selection takes effect only once the queue is completely empty. While a change is pending, both write ports are closed so the queue drains, and a busy output reports the wait.

Top module: `uopq_top`

## Requirements
- R1: After reset the current mode is dual-thread (code 0), no read is offered, the change-pending flag is low and both write ports are ready.
- R2: In dual-thread mode a thread holds at most DEPTH/2 entries (8 by default); with no reads, its write ready drops after exactly that many accepted writes.
- R3: A thread whose half is full leaves the other thread's write ready high, and that thread's writes are still accepted.
- R4: Within one thread, entries leave in the order they were accepted. An entry accepted at a clock edge is offered on the read port right after that edge.
- R5: When both threads hold entries, each read transfer goes to the thread not served by the previous transfer, and `rdThread` (0 or 1) names the thread that owns the word.
- R6: When only one thread holds entries, that thread is offered on every cycle, whichever thread had the turn.
- R7: In mode code 1 only thread 0 is active. It may hold all DEPTH entries (16 by default), while thread 1's write ready stays low and its writes are dropped.
- R8: In mode code 2 only thread 1 is active. It may hold all DEPTH entries, while thread 0's write ready stays low and its writes are dropped.
- R9: A `modeSel` value (0, 1 or 2) that differs from the current mode raises `modeBusy`, forces both write readies low and leaves the mode unchanged while any entry is stored. It takes effect at the first clock edge at which the queue is empty. The value 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 2 | Requested mode: 0 dual-thread, 1 thread 0 only, 2 thread 1 only, 3 ignored |
| modeCur | output | 2 | Mode in force, same encoding |
| modeBusy | output | 1 | A requested mode change is waiting for the queue to empty |
| wrValid0 | input | 1 | Thread 0 offers a micro-op |
| wrReady0 | output | 1 | Thread 0 write accepted this cycle if valid |
| wrData0 | input | PAYLOAD_W | Thread 0 micro-op payload |
| wrValid1 | input | 1 | Thread 1 offers a micro-op |
| wrReady1 | output | 1 | Thread 1 write accepted this cycle if valid |
| wrData1 | input | PAYLOAD_W | Thread 1 micro-op payload |
| rdValid | output | 1 | A micro-op is offered downstream |
| rdReady | input | 1 | Downstream takes the offered micro-op |
| rdData | output | PAYLOAD_W | Offered micro-op payload |
| rdThread | output | 1 | Thread that owns the offered micro-op |

## Verification
Write readies, `rdValid`, `rdThread` and `rdData` depend only on stored state and the mode request, so each one reflects a write or pop one clock edge after the transfer. A mode request moves `modeBusy` and the readies in the same cycle it is applied. A new mode appears on `modeCur` one edge after the cycle in which the queue is seen empty. The bench therefore drives inputs just after a rising edge and compares outputs a few nanoseconds later, still inside the same cycle. Each vector row states the outputs due for the state left by the preceding rows. Drain loops record one word per edge until `rdValid` falls, then compare the recorded thread and data sequence.

// File: rtl/uopq_pkg.sv
package uopq_pkg;

  typedef enum logic [1:0] {
    MODE_DUAL = 2'd0,
    MODE_SOLO0 = 2'd1,
    MODE_SOLO1 = 2'd2
  } uopqMode_e;

  typedef struct packed {
    logic wrEn0;
    logic wrEn1;
    logic popEn;
  } uopqStrobe_t;

endpackage

// File: rtl/uopq_thread_ptr.sv
module uopq_thread_ptr #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic [CNT_W-1:0] cap,
  input  logic             push,
  input  logic             pop,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] lastSlot;
  logic [IDX_W-1:0] headNext;
  logic [IDX_W-1:0] tailNext;

  assign lastSlot = CNT_W'(cap - CNT_W'(1));

  // advance within the region [0, cap)
  always_comb begin
    headNext = (CNT_W'(head) == lastSlot) ? '0 : IDX_W'(head + IDX_W'(1));
    tailNext = (CNT_W'(tail) == lastSlot) ? '0 : IDX_W'(tail + IDX_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= tailNext;
      if (pop)  head <= headNext;
      case ({push, pop})
        2'b10:   count <= CNT_W'(count + CNT_W'(1));
        2'b01:   count <= CNT_W'(count - CNT_W'(1));
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (count < cap)); // R2

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> (count != '0)); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!push && !pop && !clear) |=> $stable(count)); // R4

endmodule

// File: rtl/uopq_ctrl.sv
module uopq_ctrl
  import uopq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int HALF  = DEPTH / 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic [1:0]       wrValid,
  input  logic             rdReady,
  output logic [1:0]       wrReady,
  output logic             rdValid,
  output logic             rdThread,
  output logic [1:0]       modeCur,
  output logic             modeBusy,
  output uopqStrobe_t      stb,
  output logic [IDX_W-1:0] wrIdx0,
  output logic [IDX_W-1:0] wrIdx1,
  output logic [IDX_W-1:0] rdIdx
);

  uopqMode_e        modeQ;
  logic             lastQ;
  logic             reqLegal;
  logic             allEmpty;
  logic             applyMode;
  logic             turn;
  logic             pick;
  logic [1:0]       hasWork;
  logic [1:0]       push;
  logic [1:0]       pop;
  logic [CNT_W-1:0] cap   [2];
  logic [IDX_W-1:0] base  [2];
  logic [IDX_W-1:0] head  [2];
  logic [IDX_W-1:0] tail  [2];
  logic [CNT_W-1:0] count [2];

  // region of the array owned by each thread in the current mode
  always_comb begin
    base[0] = '0;
    base[1] = '0;
    cap[0]  = '0;
    cap[1]  = '0;
    case (modeQ)
      MODE_SOLO0: cap[0] = CNT_W'(DEPTH);
      MODE_SOLO1: cap[1] = CNT_W'(DEPTH);
      default: begin
        cap[0]  = CNT_W'(HALF);
        cap[1]  = CNT_W'(HALF);
        base[1] = IDX_W'(HALF);
      end
    endcase
  end

  assign reqLegal  = (modeSel != 2'd3);
  assign modeBusy  = reqLegal && (modeSel != modeQ);
  assign allEmpty  = (hasWork == 2'b00);
  assign applyMode = modeBusy && allEmpty;

  for (genvar t = 0; t < 2; t++) begin : g_thr
    assign hasWork[t] = (count[t] != '0);
    assign wrReady[t] = (count[t] < cap[t]) && !modeBusy;
    assign push[t]    = wrValid[t] && wrReady[t];
    assign pop[t]     = rdValid && rdReady && (pick == 1'(t));

    uopq_thread_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk   (clk),
      .rstN  (rstN),
      .clear (applyMode),
      .cap   (cap[t]),
      .push  (push[t]),
      .pop   (pop[t]),
      .head  (head[t]),
      .tail  (tail[t]),
      .count (count[t])
    );
  end

  // alternate on turn, fall through to the other thread if idle
  assign turn     = ~lastQ;
  assign pick     = hasWork[turn] ? turn : ~turn;
  assign rdValid  = |hasWork;
  assign rdThread = pick;

  assign wrIdx0 = IDX_W'(base[0] + tail[0]);
  assign wrIdx1 = IDX_W'(base[1] + tail[1]);
  assign rdIdx  = pick ? IDX_W'(base[1] + head[1]) : IDX_W'(base[0] + head[0]);

  assign stb.wrEn0 = push[0];
  assign stb.wrEn1 = push[1];
  assign stb.popEn = |pop;

  assign modeCur = modeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE_DUAL;
      lastQ <= 1'b1;
    end else begin
      if (applyMode) modeQ <= uopqMode_e'(modeSel);
      if (stb.popEn) lastQ <= pick;
    end
  end

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !allEmpty |=> (modeQ == $past(modeQ))); // R9

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    modeBusy |-> (wrReady == 2'b00)); // R9

  AST_SOLO0_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_SOLO0) |-> !wrReady[1]); // R7

  AST_SOLO1_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_SOLO1) |-> !wrReady[0]); // R8

  AST_ALTERNATE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.popEn && hasWork == 2'b11) |=> (lastQ != $past(lastQ))); // R5

  AST_NO_BUBBLE: assert property (@(posedge clk) disable iff (!rstN)
    (hasWork != 2'b00) |-> rdValid); // R6

  AST_HALF_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_DUAL) |-> (count[0] <= CNT_W'(HALF) && count[1] <= CNT_W'(HALF))); // R2

endmodule

// File: rtl/uopq_store.sv
module uopq_store
  import uopq_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int PAYLOAD_W = 16,
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  uopqStrobe_t          stb,
  input  logic [IDX_W-1:0]     wrIdx0,
  input  logic [IDX_W-1:0]     wrIdx1,
  input  logic [PAYLOAD_W-1:0] wrData0,
  input  logic [PAYLOAD_W-1:0] wrData1,
  input  logic [IDX_W-1:0]     rdIdx,
  output logic [PAYLOAD_W-1:0] rdData
);

  logic [PAYLOAD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (stb.wrEn0) mem[wrIdx0] <= wrData0;
    if (stb.wrEn1) mem[wrIdx1] <= wrData1;
  end

  assign rdData = mem[rdIdx];

  AST_WR_DISJOINT: assert property (@(posedge clk)
    (stb.wrEn0 && stb.wrEn1) |-> (wrIdx0 != wrIdx1)); // R3

endmodule

// File: rtl/uopq_top.sv
module uopq_top
  import uopq_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int PAYLOAD_W = 16,
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           modeSel,
  output logic [1:0]           modeCur,
  output logic                 modeBusy,
  input  logic                 wrValid0,
  output logic                 wrReady0,
  input  logic [PAYLOAD_W-1:0] wrData0,
  input  logic                 wrValid1,
  output logic                 wrReady1,
  input  logic [PAYLOAD_W-1:0] wrData1,
  output logic                 rdValid,
  input  logic                 rdReady,
  output logic [PAYLOAD_W-1:0] rdData,
  output logic                 rdThread
);

  uopqStrobe_t      stb;
  logic [1:0]       wrReady;
  logic [IDX_W-1:0] wrIdx0;
  logic [IDX_W-1:0] wrIdx1;
  logic [IDX_W-1:0] rdIdx;

  assign wrReady0 = wrReady[0];
  assign wrReady1 = wrReady[1];

  uopq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .modeSel  (modeSel),
    .wrValid  ({wrValid1, wrValid0}),
    .rdReady  (rdReady),
    .wrReady  (wrReady),
    .rdValid  (rdValid),
    .rdThread (rdThread),
    .modeCur  (modeCur),
    .modeBusy (modeBusy),
    .stb      (stb),
    .wrIdx0   (wrIdx0),
    .wrIdx1   (wrIdx1),
    .rdIdx    (rdIdx)
  );

  uopq_store #(.DEPTH(DEPTH), .PAYLOAD_W(PAYLOAD_W)) u_store (
    .clk     (clk),
    .stb     (stb),
    .wrIdx0  (wrIdx0),
    .wrIdx1  (wrIdx1),
    .wrData0 (wrData0),
    .wrData1 (wrData1),
    .rdIdx   (rdIdx),
    .rdData  (rdData)
  );

endmodule

// File: tb/sim_uopq_top.sv
module sim_uopq_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  modeSel;
  logic [1:0]  modeCur;
  logic        modeBusy;
  logic        wrValid0, wrReady0, wrValid1, wrReady1;
  logic [15:0] wrData0, wrData1;
  logic        rdValid, rdReady, rdThread;
  logic [15:0] rdData;

  int nCmp = 0;
  int nBad = 0;
  bit done = 0;

  logic [7:0] gotD [32];
  logic       gotT [32];
  int         nGot;

  always #10 clk = ~clk;

  uopq_top u0 (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .modeCur(modeCur), .modeBusy(modeBusy),
    .wrValid0(wrValid0), .wrReady0(wrReady0), .wrData0(wrData0),
    .wrValid1(wrValid1), .wrReady1(wrReady1), .wrData1(wrData1),
    .rdValid(rdValid), .rdReady(rdReady), .rdData(rdData), .rdThread(rdThread)
  );

  // row: eRv eRt eRd[7:0] eW0 eW1 | wv0 wd0[7:0] wv1 wd1[7:0] rr
  localparam int NV = 10;
  localparam logic [30:0] VEC [NV] = '{
    {1'b0,1'b0,8'h00,1'b1,1'b1, 1'b1,8'hA1,1'b1,8'hB1,1'b0},
    {1'b1,1'b0,8'hA1,1'b1,1'b1, 1'b1,8'hA2,1'b1,8'hB2,1'b1},
    {1'b1,1'b1,8'hB1,1'b1,1'b1, 1'b0,8'h00,1'b0,8'h00,1'b1},
    {1'b1,1'b0,8'hA2,1'b1,1'b1, 1'b0,8'h00,1'b0,8'h00,1'b1},
    {1'b1,1'b1,8'hB2,1'b1,1'b1, 1'b0,8'h00,1'b0,8'h00,1'b1},
    {1'b0,1'b0,8'h00,1'b1,1'b1, 1'b0,8'h00,1'b1,8'hB3,1'b0},
    {1'b1,1'b1,8'hB3,1'b1,1'b1, 1'b0,8'h00,1'b1,8'hB4,1'b1},
    {1'b1,1'b1,8'hB4,1'b1,1'b1, 1'b0,8'h00,1'b1,8'hB5,1'b1},
    {1'b1,1'b1,8'hB5,1'b1,1'b1, 1'b0,8'h00,1'b0,8'h00,1'b1},
    {1'b0,1'b0,8'h00,1'b1,1'b1, 1'b0,8'h00,1'b0,8'h00,1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drain();
    nGot = 0;
    rdReady = 1'b1;
    #4;
    while (rdValid && nGot < 32) begin
      gotD[nGot] = rdData[7:0];
      gotT[nGot] = rdThread;
      nGot++;
      tick();
      #4;
    end
    rdReady = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    nCmp++;
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int a0;
    int a1;
    rstN = 1'b0; modeSel = 2'd0; rdReady = 1'b0;
    wrValid0 = 1'b0; wrValid1 = 1'b0; wrData0 = '0; wrData1 = '0;
    tick(); tick();
    rstN = 1'b1;
    #4;
    // R1 reset state
    check("R1 modeCur", 32'(modeCur), 0);
    check("R1 rdValid", 32'(rdValid), 0);
    check("R1 modeBusy", 32'(modeBusy), 0);
    check("R1 wrReady0", 32'(wrReady0), 1);
    check("R1 wrReady1", 32'(wrReady1), 1);

    // vector table: R4 order, R5 alternation, R6 no bubble
    for (int i = 0; i < NV; i++) begin
      logic [30:0] v;
      v = VEC[i];
      check("R6 table rdValid", 32'(rdValid), 32'(v[30]));
      if (v[30]) begin
        check("R5 table rdThread", 32'(rdThread), 32'(v[29]));
        check("R4 table rdData", 32'(rdData), {24'h0, v[28:21]});
      end
      check("R3 table wrReady0", 32'(wrReady0), 32'(v[20]));
      check("R3 table wrReady1", 32'(wrReady1), 32'(v[19]));
      wrValid0 = v[18]; wrData0 = {8'h00, v[17:10]};
      wrValid1 = v[9];  wrData1 = {8'h00, v[8:1]};
      rdReady  = v[0];
      tick();
      #4;
    end
    wrValid0 = 0; wrValid1 = 0; rdReady = 0;

    // R2/R3: fill thread 0 half, thread 1 still open
    a0 = 0;
    for (int i = 0; i < 9; i++) begin
      wrValid0 = 1'b1; wrData0 = 16'(8'h10 + i);
      #4;
      if (wrReady0) a0++;
      tick();
    end
    wrValid0 = 0;
    #4;
    check("R2 accepted in half", 32'(a0), 8);
    check("R2 wrReady0 full", 32'(wrReady0), 0);
    check("R3 wrReady1 open", 32'(wrReady1), 1);
    wrValid1 = 1'b1; wrData1 = 16'h0055;
    tick();
    wrValid1 = 0;
    drain();
    check("R4 drained count", 32'(nGot), 9);
    check("R5 first thread", 32'(gotT[0]), 0);
    check("R5 second thread", 32'(gotT[1]), 1);
    check("R3 thread1 word", 32'(gotD[1]), 32'h55);
    check("R4 t0 first", 32'(gotD[0]), 32'h10);
    for (int i = 2; i < 9; i++) check("R4 t0 order", 32'(gotD[i]), 32'(8'h10 + i - 1));

    // R9 mode change held while not empty
    wrValid0 = 1'b1; wrData0 = 16'h0020; tick();
    wrData0 = 16'h0021; tick();
    wrData0 = 16'h0099;
    modeSel = 2'd1;
    #4;
    check("R9 busy", 32'(modeBusy), 1);
    check("R9 mode held", 32'(modeCur), 0);
    check("R9 wrReady0 closed", 32'(wrReady0), 0);
    check("R9 wrReady1 closed", 32'(wrReady1), 0);
    tick();
    drain();
    wrValid0 = 0;
    check("R9 drained", 32'(nGot), 2);
    check("R9 first word", 32'(gotD[0]), 32'h20);
    check("R9 second word", 32'(gotD[1]), 32'h21);
    tick();
    #4;
    check("R9 mode applied", 32'(modeCur), 1);
    check("R9 busy cleared", 32'(modeBusy), 0);

    // R7 solo thread 0
    a0 = 0; a1 = 0;
    check("R7 wrReady1 low", 32'(wrReady1), 0);
    for (int i = 0; i < 17; i++) begin
      wrValid0 = 1'b1; wrData0 = 16'(8'h30 + i);
      wrValid1 = 1'b1; wrData1 = 16'h0077;
      #4;
      if (wrReady0) a0++;
      if (wrReady1) a1++;
      tick();
    end
    wrValid0 = 0; wrValid1 = 0;
    check("R7 t0 accepted", 32'(a0), 16);
    check("R7 t1 accepted", 32'(a1), 0);
    drain();
    check("R7 drained", 32'(nGot), 16);
    for (int i = 0; i < 16; i++) begin
      check("R7 thread", 32'(gotT[i]), 0);
      check("R7 order", 32'(gotD[i]), 32'(8'h30 + i));
    end

    // R8 solo thread 1
    modeSel = 2'd2;
    tick();
    #4;
    check("R8 mode applied", 32'(modeCur), 2);
    check("R8 wrReady0 low", 32'(wrReady0), 0);
    a0 = 0; a1 = 0;
    for (int i = 0; i < 17; i++) begin
      wrValid1 = 1'b1; wrData1 = 16'(8'h40 + i);
      wrValid0 = 1'b1; wrData0 = 16'h0066;
      #4;
      if (wrReady0) a0++;
      if (wrReady1) a1++;
      tick();
    end
    wrValid0 = 0; wrValid1 = 0;
    check("R8 t1 accepted", 32'(a1), 16);
    check("R8 t0 accepted", 32'(a0), 0);
    drain();
    check("R8 drained", 32'(nGot), 16);
    for (int i = 0; i < 16; i++) begin
      check("R8 thread", 32'(gotT[i]), 1);
      check("R8 order", 32'(gotD[i]), 32'(8'h40 + i));
    end

    // R9 code 3 ignored, then back to dual
    modeSel = 2'd3;
    tick(); tick();
    #4;
    check("R9 code3 busy", 32'(modeBusy), 0);
    check("R9 code3 mode", 32'(modeCur), 2);
    modeSel = 2'd0;
    tick();
    #4;
    check("R9 back to dual", 32'(modeCur), 0);
    check("R1 dual wrReady0", 32'(wrReady0), 1);
    check("R1 dual wrReady1", 32'(wrReady1), 1);

    finishRun();
  end

endmodule